// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This combinational unit forms the second source operand of a 32-bit data-processing instruction. It reads the instruction word, the value of the register named as the shifted source (Rm), the low byte of the register that can supply a shift amount (Rs) and the current carry flag. It returns the 32-bit operand together with the shifter carry-out, which the flag logic uses for logical operations that update flags.

There are two operand forms. The first is an 8-bit constant rotated right by an even amount. The second is the Rm value shifted left or right, arithmetically shifted, or rotated. The shift amount is either a 5-bit constant in the instruction or the low byte of Rs. Some zero-amount encodings of the constant form have special meanings: a right shift by zero means a shift by 32, and a rotate by zero means a one-bit rotate through carry. Amounts taken from Rs follow a separate set of carry rules for amounts of 32 and above.

Top module: `shift_operand_unit`

## Requirements
- R1: Instruction bit 25 selects the form. When it is 1 the operand is the rotated constant, and Rm, Rs and bits 6:4 have no effect. When it is 0 the operand is the shifted Rm value.
- R2: Constant form: the operand is instr[7:0], zero-extended and rotated right by 2*instr[11:8]. The carry-out is c_in when that rotate amount is 0, and operand bit 31 otherwise.
- R3: Shift type is instr[6:5] (0 left, 1 logical right, 2 arithmetic right, 3 rotate right), and instr[4]=1 takes the amount from Rs. Otherwise the amount is instr[11:7]. A constant left shift by 0 gives Rm with carry c_in. A constant left shift by n gives Rm<<n with carry Rm bit (32-n).
- R4: A constant logical or arithmetic right shift with amount field 0 shifts by 32. The logical form gives 0, the arithmetic form gives 32 copies of Rm bit 31, and the carry is Rm bit 31 in both cases.
- R5: A constant rotate with amount field 0 gives {c_in, Rm[31:1]} with carry Rm bit 0.
- R6: For a nonzero amount n below 32, logical right, arithmetic right and rotate right give carry Rm bit (n-1).
- R7: A register amount of 0 gives Rm unchanged with carry c_in, for every shift type.
- R8: With a register amount, a left or logical right shift by exactly 32 gives 0. The carry is Rm bit 0 for the left shift and Rm bit 31 for the right shift. Amounts from 33 to 255 give 0 with carry 0.
- R9: With a register amount of 32 or more, an arithmetic right shift gives 32 copies of Rm bit 31, and the carry is that bit.
- R10: A register rotate uses the amount modulo 32. A nonzero multiple of 32 gives Rm unchanged with carry Rm bit 31. Only the 8 bits on rs_low count as the amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the shifted source register |
| rs_low | input | 8 | Low byte of the amount register |
| c_in | input | 1 | Current carry flag |
| operand | output | 32 | Second operand |
| shc_out | output | 1 | Shifter carry-out |

## Verification
The unit has no registers, so each result is due in the same cycle as the input vector that produces it. The driver applies a vector on the falling clock edge and queues the expected operand and carry. The monitor then takes the vector from the queue 2 ns after the next rising edge, while the inputs are still stable. Expected values come from a model that shifts one bit per step and records the bit that falls out at each step. The zero-amount reinterpretations in the constant form are modelled as separate cases.

// File: rtl/shift_operand_unit.sv
module shift_operand_unit #(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rm_val,
  input  logic [7:0]        rs_low,
  input  logic              c_in,
  output logic [DATA_W-1:0] operand,
  output logic              shc_out
);
  localparam int AMT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} sh_kind_t;

  logic              imm_form, by_reg, sign;
  sh_kind_t          kind;
  logic [AMT_W-1:0]  rot, n;
  logic [DATA_W-1:0] imm_ext, imm_rot;
  logic [DATA_W-1:0] lsl_r, lsr_r, asr_r, ror_r;
  logic              lsl_c, right_c, big, exact;
  logic              unused_bits;

  assign unused_bits = ^{instr[31:26], instr[24:12]};

  assign imm_form = instr[25];
  assign by_reg   = instr[4];
  assign kind     = sh_kind_t'(instr[6:5]);
  assign sign     = rm_val[DATA_W-1];
  assign rot      = {instr[11:8], 1'b0};
  assign imm_ext  = {{(DATA_W-8){1'b0}}, instr[7:0]};
  assign imm_rot  = (imm_ext >> rot) | (imm_ext << (DATA_W - int'(rot)));

  assign n        = by_reg ? rs_low[AMT_W-1:0] : instr[11:7];
  assign lsl_r    = rm_val << n;
  assign lsr_r    = rm_val >> n;
  assign asr_r    = $signed(rm_val) >>> n;
  assign ror_r    = (rm_val >> n) | (rm_val << (DATA_W - int'(n)));
  assign lsl_c    = rm_val[AMT_W'(DATA_W - int'(n))];
  assign right_c  = rm_val[n - AMT_W'(1)];
  assign big      = rs_low >= 8'(DATA_W);
  assign exact    = rs_low == 8'(DATA_W);

  always_comb begin
    operand = rm_val;
    shc_out = c_in;
    if (imm_form) begin
      operand = imm_rot;
      shc_out = (rot == '0) ? c_in : imm_rot[DATA_W-1];
    end else if (!by_reg) begin
      unique case (kind)
        SH_LSL: if (n != '0) begin
          operand = lsl_r;
          shc_out = lsl_c;
        end
        SH_LSR: if (n == '0) begin
          operand = '0;
          shc_out = sign;
        end else begin
          operand = lsr_r;
          shc_out = right_c;
        end
        SH_ASR: if (n == '0) begin
          operand = {DATA_W{sign}};
          shc_out = sign;
        end else begin
          operand = asr_r;
          shc_out = right_c;
        end
        default: if (n == '0) begin
          operand = {c_in, rm_val[DATA_W-1:1]};
          shc_out = rm_val[0];
        end else begin
          operand = ror_r;
          shc_out = right_c;
        end
      endcase
    end else if (rs_low != 8'd0) begin
      unique case (kind)
        SH_LSL: if (!big) begin
          operand = lsl_r;
          shc_out = lsl_c;
        end else begin
          operand = '0;
          shc_out = exact & rm_val[0];
        end
        SH_LSR: if (!big) begin
          operand = lsr_r;
          shc_out = right_c;
        end else begin
          operand = '0;
          shc_out = exact & sign;
        end
        SH_ASR: if (!big) begin
          operand = asr_r;
          shc_out = right_c;
        end else begin
          operand = {DATA_W{sign}};
          shc_out = sign;
        end
        default: if (n == '0) begin
          operand = rm_val;
          shc_out = sign;
        end else begin
          operand = ror_r;
          shc_out = right_c;
        end
      endcase
    end
  end
endmodule

// File: rtl/shift_operand_unit_chk.sv
module shift_operand_unit_chk (
  input logic [31:0] instr,
  input logic [31:0] rm_val,
  input logic [7:0]  rs_low,
  input logic        c_in,
  input logic [31:0] operand,
  input logic        shc_out
);
  always_comb begin
    if (!$isunknown({instr, rm_val, rs_low, c_in})) begin
      if (instr[25] && instr[11:8] == 4'd0)
        AST_IMM_NO_ROTATE: assert (operand == {24'd0, instr[7:0]} && shc_out == c_in); // R2
      if (instr[25])
        AST_IMM_HIGH_ZERO: assert ($countones(operand) <= 8); // R1
      if (!instr[25] && !instr[4] && instr[6:5] == 2'd0 && instr[11:7] == 5'd0)
        AST_LSL_ZERO_PASS: assert (operand == rm_val && shc_out == c_in); // R3
      if (!instr[25] && !instr[4] && instr[6:5] == 2'd3 && instr[11:7] == 5'd0)
        AST_RRX_FORM: assert (operand == {c_in, rm_val[31:1]} && shc_out == rm_val[0]); // R5
      if (!instr[25] && instr[4] && rs_low == 8'd0)
        AST_REG_ZERO_AMT: assert (operand == rm_val && shc_out == c_in); // R7
      if (!instr[25] && instr[4] && !instr[6] && rs_low > 8'd32)
        AST_REG_OVER_RANGE: assert (operand == 32'd0 && !shc_out); // R8
      if (!instr[25] && instr[4] && instr[6:5] == 2'd2 && rs_low >= 8'd32)
        AST_ASR_SIGN_FILL: assert (operand == {32{rm_val[31]}} && shc_out == rm_val[31]); // R9
    end
  end
endmodule

bind shift_operand_unit shift_operand_unit_chk u_chk (
  .instr(instr), .rm_val(rm_val), .rs_low(rs_low), .c_in(c_in),
  .operand(operand), .shc_out(shc_out)
);

// File: tb/sim_shift_operand_unit.sv
`timescale 1ns/1ps
module sim_shift_operand_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr, rm_val, operand;
  logic [7:0]  rs_low;
  logic        c_in, shc_out;

  shift_operand_unit u0 (
    .instr(instr), .rm_val(rm_val), .rs_low(rs_low), .c_in(c_in),
    .operand(operand), .shc_out(shc_out)
  );

  typedef struct { logic [31:0] op; logic c; string tag; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic exp_t model(input logic [31:0] ir, input logic [31:0] rm,
                                 input logic [7:0] rs, input logic cf);
    exp_t e;
    logic [31:0] v;
    logic c;
    int amt;
    c = cf;
    if (ir[25]) begin
      v = {24'd0, ir[7:0]};
      for (int i = 0; i < 2 * int'(ir[11:8]); i++) begin c = v[0]; v = {v[0], v[31:1]}; end
    end else begin
      v = rm;
      amt = ir[4] ? int'(rs) : int'(ir[11:7]);
      if (!ir[4] && amt == 0 && ir[6:5] != 2'd0)
        amt = (ir[6:5] == 2'd3) ? -1 : 32;
      if (amt < 0) begin
        c = v[0]; v = {cf, v[31:1]};
      end else begin
        for (int i = 0; i < amt; i++) begin
          case (ir[6:5])
            2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
            2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
            2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
            default: begin c = v[0]; v = {v[0], v[31:1]}; end
          endcase
        end
      end
    end
    e.op = v; e.c = c; e.tag = "";
    return e;
  endfunction

  task automatic drive(input logic [31:0] ir, input logic [31:0] rm,
                       input logic [7:0] rs, input logic cf, input string tag);
    exp_t e;
    @(negedge clk);
    instr = ir; rm_val = rm; rs_low = rs; c_in = cf;
    e = model(ir, rm, rs, cf);
    e.tag = tag;
    sb.push_back(e);
  endtask

  function automatic logic [31:0] imm_ir(input int rot4, input int imm8);
    return 32'h0200_0000 | 32'(rot4 << 8) | 32'(imm8);
  endfunction
  function automatic logic [31:0] shi_ir(input int kind, input int amt);
    return 32'(amt << 7) | 32'(kind << 5);
  endfunction
  function automatic logic [31:0] shr_ir(input int kind);
    return 32'h0000_0010 | 32'(kind << 5);
  endfunction

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        total++;
        if (operand !== e.op || shc_out !== e.c) begin
          bad++;
          $display("FAIL %s: got op=%h c=%b expected op=%h c=%b", e.tag, operand, shc_out, e.op, e.c);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    instr = '0; rm_val = '0; rs_low = '0; c_in = 1'b0;
    drive(imm_ir(0, 8'hA5), 32'hFFFF_FFFF, 8'd3, 1'b1, "R1 imm ignores rm");
    drive(imm_ir(0, 8'hA5) | 32'h70, 32'h1234_5678, 8'd200, 1'b0, "R1 imm ignores 6:4");
    drive(shi_ir(0, 4), 32'h0000_00F1, 8'd0, 1'b0, "R1 register form");
    drive(imm_ir(0, 8'h80), 32'd0, 8'd0, 1'b1, "R2 rot0 carry=c_in");
    drive(imm_ir(1, 8'h03), 32'd0, 8'd0, 1'b0, "R2 rot2 wraps bit31");
    drive(imm_ir(4, 8'hFF), 32'd0, 8'd0, 1'b1, "R2 rot8");
    drive(imm_ir(15, 8'h81), 32'd0, 8'd0, 1'b0, "R2 rot30");
    drive(shi_ir(0, 0), 32'hDEAD_BEEF, 8'd0, 1'b1, "R3 lsl0 pass");
    drive(shi_ir(0, 1), 32'h8000_0001, 8'd0, 1'b0, "R3 lsl1");
    drive(shi_ir(0, 31), 32'h0000_0003, 8'd0, 1'b0, "R3 lsl31");
    drive(shi_ir(1, 0), 32'h8000_0000, 8'd0, 1'b0, "R4 lsr32");
    drive(shi_ir(2, 0), 32'h8000_1234, 8'd0, 1'b0, "R4 asr32 neg");
    drive(shi_ir(2, 0), 32'h7000_1234, 8'd0, 1'b1, "R4 asr32 pos");
    drive(shi_ir(3, 0), 32'h0000_0003, 8'd0, 1'b1, "R5 rrx c1");
    drive(shi_ir(3, 0), 32'h8000_0002, 8'd0, 1'b0, "R5 rrx c0");
    drive(shi_ir(1, 4), 32'h0000_0018, 8'd0, 1'b0, "R6 lsr4");
    drive(shi_ir(2, 31), 32'hC000_0000, 8'd0, 1'b0, "R6 asr31");
    drive(shi_ir(3, 8), 32'h1234_5680, 8'd0, 1'b0, "R6 ror8");
    for (int k = 0; k < 4; k++) drive(shr_ir(k), 32'h9ABC_DEF0, 8'd0, k[0], "R7 reg amt0");
    drive(shr_ir(0), 32'h0000_0001, 8'd32, 1'b0, "R8 lsl32");
    drive(shr_ir(1), 32'h8000_0000, 8'd32, 1'b0, "R8 lsr32");
    drive(shr_ir(0), 32'hFFFF_FFFF, 8'd33, 1'b1, "R8 lsl33");
    drive(shr_ir(1), 32'hFFFF_FFFF, 8'd255, 1'b1, "R8 lsr255");
    drive(shr_ir(0), 32'h4000_0000, 8'd2, 1'b0, "R8 lsl2 reg");
    drive(shr_ir(2), 32'h8000_0000, 8'd32, 1'b0, "R9 asr32");
    drive(shr_ir(2), 32'h7FFF_FFFF, 8'd200, 1'b1, "R9 asr200");
    drive(shr_ir(2), 32'h8000_0010, 8'd5, 1'b0, "R9 asr5");
    drive(shr_ir(3), 32'h8000_0001, 8'd32, 1'b0, "R10 ror32");
    drive(shr_ir(3), 32'h0000_0001, 8'd64, 1'b1, "R10 ror64");
    drive(shr_ir(3), 32'h0000_0010, 8'd37, 1'b0, "R10 ror37");
    drive(shr_ir(3), 32'h0000_0003, 8'd1, 1'b0, "R10 ror1");
    for (int k = 1; k < 32; k += 5) drive(shi_ir(k % 4, k), 32'hA5C3_0F96, 8'd0, 1'b1, "R6 sweep");
    @(negedge clk);
    while (sb.size() != 0) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule